// File: doc/BRIEF.md
# HDLC Transmit Bit-Stuffing Encoder

This block turns a stream of 8-bit source bytes into the bit sequence that goes inside an HDLC frame, and packs that sequence back into 8-bit words. Whenever five 1 bits in a row have gone out, it inserts a 0. It also keeps a running 16-bit frame check value over the bits it converts. The block does not handle flags, frame assembly, line coding or serial pins. Software or an upstream engine writes source bytes into a one-byte input register. A downstream consumer reads finished words from a one-word output register that has a valid flag.

The block converts one output bit per clock. It waits while a finished word has not been read. Once started, it keeps running when no source byte is waiting, and then converts idle 1 bits. Dropping the transmit enable restarts the conversion state and the check value. The input and output registers keep their contents.

Top module: `hdlc_tx_stuffer`

## Requirements
- R1: When the last five bits placed in the output stream are all 1, the next output bit is an inserted 0. The run count includes idle fill bits. An inserted 0 ends the run.
- R2: Input and output words are 8 bits wide. Source bits are taken from bit 0 upward. Output bits are packed from bit 0 upward, so `out_data[0]` is the earliest bit of a word.
- R3: While `out_valid` is 1, conversion is halted, and `out_data` and `crc_value` hold still. A cycle with `out_rd` high clears `out_valid` at the next edge, and conversion then continues.
- R4: After conversion has started, if no source byte is waiting when a new source bit is needed, a 1 bit is converted in its place.
- R5: `crc_value` shows the raw check register. On every converted bit that is not an inserted 0, the register is shifted one place toward bit 0. If the old bit 0 XOR the converted bit is 1, the register is then XORed with 16'h8408 (x^16+x^12+x^5+1, bit-reversed).
- R6: One clock with `tx_en` low returns `crc_value` to 16'hFFFF. It also drops the partly converted byte, the partly packed word and the run count. `out_valid`, `out_data` and a waiting source byte are unchanged.
- R7: Conversion begins only when `tx_en` is 1 and a written source byte is waiting. Before that, `out_valid` stays 0 and `crc_value` stays 16'hFFFF.
- R8: After reset, `out_valid` is 0, `out_data` is 8'h00 and `crc_value` is 16'hFFFF.
- R9: A write to the source register while an earlier byte is still waiting replaces that byte. The replaced byte is never converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable; low clears the conversion state and the check value |
| src_wr | input | 1 | Write strobe for the source byte register |
| src_data | input | 8 | Source byte |
| out_rd | input | 1 | Read strobe for the output word register |
| out_data | output | 8 | Converted output word, earliest bit in bit 0 |
| out_valid | output | 1 | Output word waiting to be read |
| crc_value | output | 16 | Current check register |

## Verification
The assertions check these properties on every cycle:
- The run count never passes five.
- An inserted 0 always clears the run count.
- An unread word and the check value hold still while the block waits.
- The check register reseeds after `tx_en` drops.
- Conversion never starts without a waiting byte.

Some behaviour only the bench scenarios can show: the exact bit order inside packed words, where stuffing falls across byte and word boundaries, idle fill after the data runs out, and a waiting byte being replaced. The bench compares every cycle against a bit-level model built from the requirements, and it also checks a few words worked out by hand.

// File: rtl/hdlc_stuff_pkg.sv
package hdlc_stuff_pkg;

    localparam int          WORD_W     = 8;
    localparam int          CHK_W      = 16;
    localparam logic [15:0] CHK_POLY_R = 16'h8408;
    localparam logic [15:0] CHK_SEED   = 16'hFFFF;
    localparam int          RUN_MAX    = 5;

    typedef enum logic [1:0] {
        BIT_SOURCE = 2'd0,
        BIT_IDLE   = 2'd1,
        BIT_STUFF  = 2'd2
    } bit_kind_e;

    typedef struct packed {
        logic      value;
        bit_kind_e kind;
    } conv_bit_t;

    function automatic logic counts_in_check(input conv_bit_t b);
        return (b.kind != BIT_STUFF);
    endfunction

endpackage

// File: rtl/stuff_src_feed.sv
module stuff_src_feed #(
    parameter int W = hdlc_stuff_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         src_wr,
    input  logic [W-1:0] src_data,
    input  logic         take,
    output logic         bit_o,
    output logic         idle_o,
    output logic         pending_o
);
    localparam int LEFT_W = $clog2(W + 1);

    logic [W-1:0]      hold_q;
    logic              full_q;
    logic [W-1:0]      shift_q;
    logic [LEFT_W-1:0] left_q;

    always_comb begin
        if (left_q != '0) begin
            bit_o  = shift_q[0];
            idle_o = 1'b0;
        end else if (full_q) begin
            bit_o  = hold_q[0];
            idle_o = 1'b0;
        end else begin
            bit_o  = 1'b1;
            idle_o = 1'b1;
        end
    end

    assign pending_o = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            shift_q <= '0;
            left_q  <= '0;
        end else begin
            if (flush) begin
                left_q <= '0;
            end else if (take) begin
                if (left_q != '0) begin
                    shift_q <= shift_q >> 1;
                    left_q  <= left_q - 1'b1;
                end else if (full_q) begin
                    shift_q <= hold_q >> 1;
                    left_q  <= LEFT_W'(W - 1);
                    full_q  <= 1'b0;
                end
            end
            if (src_wr) begin
                hold_q <= src_data;
                full_q <= 1'b1;
            end
        end
    end

    AST_FEED_LEFT_BOUND: assert property (@(posedge clk) disable iff (rst) left_q <= LEFT_W'(W - 1)) else $error("shift count overran"); // R2

endmodule

// File: rtl/stuff_chk_acc.sv
module stuff_chk_acc #(
    parameter int          CW   = hdlc_stuff_pkg::CHK_W,
    parameter logic [CW-1:0] POLY = hdlc_stuff_pkg::CHK_POLY_R,
    parameter logic [CW-1:0] SEED = hdlc_stuff_pkg::CHK_SEED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reseed,
    input  logic          upd,
    input  logic          bit_i,
    output logic [CW-1:0] chk_o
);
    logic [CW-1:0] chk_q;
    logic [CW-1:0] chk_nxt;

    always_comb begin
        chk_nxt = {1'b0, chk_q[CW-1:1]};
        if (chk_q[0] ^ bit_i) chk_nxt = chk_nxt ^ POLY;
    end

    always_ff @(posedge clk) begin
        if (rst || reseed) chk_q <= SEED;
        else if (upd)      chk_q <= chk_nxt;
    end

    assign chk_o = chk_q;

    AST_SEED_AFTER_DISABLE: assert property (@(posedge clk) disable iff (rst) reseed |=> chk_q == SEED) else $error("check value not reseeded"); // R6
    AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (rst) (!reseed && !upd) |=> $stable(chk_q)) else $error("check value moved without a bit"); // R5

endmodule

// File: rtl/stuff_packer.sv
module stuff_packer #(
    parameter int W = hdlc_stuff_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic         bit_i,
    input  logic         rd,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     acc_q;
    logic [IDX_W-1:0] idx_q;
    logic [W-1:0]     acc_nxt;
    logic             last;

    always_comb begin
        acc_nxt        = acc_q;
        acc_nxt[idx_q] = bit_i;
        last           = (idx_q == IDX_W'(W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            idx_q   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            if (rd && valid_o) valid_o <= 1'b0;
            if (flush) begin
                idx_q <= '0;
            end else if (push) begin
                acc_q <= acc_nxt;
                if (last) begin
                    word_o  <= acc_nxt;
                    valid_o <= 1'b1;
                    idx_q   <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    AST_UNREAD_WORD_HELD: assert property (@(posedge clk) disable iff (rst) (valid_o && !rd) |=> (valid_o && $stable(word_o))) else $error("unread word lost"); // R3
    AST_NO_PUSH_WHILE_FULL: assert property (@(posedge clk) disable iff (rst) valid_o |-> !push) else $error("bit pushed over unread word"); // R3

endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer
    import hdlc_stuff_pkg::*;
#(
    parameter int W       = WORD_W,
    parameter int CW      = CHK_W,
    parameter int RUN_LIM = RUN_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_en,
    input  logic          src_wr,
    input  logic [W-1:0]  src_data,
    input  logic          out_rd,
    output logic [W-1:0]  out_data,
    output logic          out_valid,
    output logic [CW-1:0] crc_value
);
    localparam int RUN_W = $clog2(RUN_LIM + 1);

    logic             run_q;
    logic [RUN_W-1:0] ones_q;
    logic             step;
    logic             feed_bit;
    logic             feed_idle;
    logic             pending;
    logic             flush;
    conv_bit_t        cur;
    logic             take;

    assign flush = !tx_en;
    assign step  = tx_en && !out_valid && (run_q || pending);

    always_comb begin
        if (ones_q == RUN_W'(RUN_LIM)) begin
            cur.value = 1'b0;
            cur.kind  = BIT_STUFF;
        end else begin
            cur.value = feed_bit;
            cur.kind  = feed_idle ? BIT_IDLE : BIT_SOURCE;
        end
    end

    assign take = step && counts_in_check(cur);

    stuff_src_feed #(.W(W)) u_feed (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .src_wr    (src_wr),
        .src_data  (src_data),
        .take      (take),
        .bit_o     (feed_bit),
        .idle_o    (feed_idle),
        .pending_o (pending)
    );

    stuff_chk_acc #(.CW(CW), .POLY(CW'(CHK_POLY_R)), .SEED(CW'(CHK_SEED))) u_chk (
        .clk    (clk),
        .rst    (rst),
        .reseed (flush),
        .upd    (take),
        .bit_i  (cur.value),
        .chk_o  (crc_value)
    );

    stuff_packer #(.W(W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .push    (step),
        .bit_i   (cur.value),
        .rd      (out_rd),
        .word_o  (out_data),
        .valid_o (out_valid)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            run_q  <= 1'b0;
            ones_q <= '0;
        end else if (step) begin
            run_q  <= 1'b1;
            ones_q <= cur.value ? ones_q + 1'b1 : '0;
        end
    end

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst) ones_q <= RUN_W'(RUN_LIM)) else $error("run of ones too long"); // R1
    AST_STUFF_ENDS_RUN: assert property (@(posedge clk) disable iff (rst) (step && ones_q == RUN_W'(RUN_LIM)) |=> ones_q == '0) else $error("stuffed zero did not end run"); // R1
    AST_CHECK_FROZEN_ON_STALL: assert property (@(posedge clk) disable iff (rst) (out_valid && tx_en) |=> $stable(crc_value)) else $error("check value moved during stall"); // R3
    AST_NO_START_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (rst) (!run_q && !pending) |=> !run_q) else $error("started without a source byte"); // R7

endmodule

// File: tb/sim_hdlc_tx_stuffer.sv
module sim_hdlc_tx_stuffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        src_wr = 1'b0;
    logic [7:0]  src_data = 8'h00;
    logic        out_rd = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic [15:0] crc_value;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    hdlc_tx_stuffer u0 (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .src_wr    (src_wr),
        .src_data  (src_data),
        .out_rd    (out_rd),
        .out_data  (out_data),
        .out_valid (out_valid),
        .crc_value (crc_value)
    );

    // Bit-level reference model written from the requirements
    logic [7:0]  m_buf, m_sh, m_acc, m_out;
    logic        m_bfull, m_run, m_valid, m_st, m_b, m_fb;
    int          m_left, m_ones, m_pcnt;
    logic [15:0] m_crc;

    always @(posedge clk) begin
        if (rst) begin
            m_buf = 0; m_sh = 0; m_acc = 0; m_out = 0; m_bfull = 0; m_run = 0;
            m_valid = 0; m_left = 0; m_ones = 0; m_pcnt = 0; m_crc = 16'hFFFF;
        end else begin
            m_st = tx_en && !m_valid && (m_run || m_bfull);
            if (out_rd && m_valid) m_valid = 0;
            if (!tx_en) begin
                m_run = 0; m_ones = 0; m_left = 0; m_pcnt = 0; m_crc = 16'hFFFF;
            end else if (m_st) begin
                if (m_ones == 5) begin
                    m_b = 0; m_ones = 0;
                end else begin
                    if (m_left > 0) begin
                        m_b = m_sh[0]; m_sh = m_sh >> 1; m_left--;
                    end else if (m_bfull) begin
                        m_b = m_buf[0]; m_sh = m_buf >> 1; m_left = 7; m_bfull = 0;
                    end else begin
                        m_b = 1;
                    end
                    m_fb = m_crc[0] ^ m_b;
                    m_crc = m_crc >> 1;
                    if (m_fb) m_crc = m_crc ^ 16'h8408;
                    m_ones = m_b ? m_ones + 1 : 0;
                end
                m_acc[m_pcnt] = m_b;
                if (m_pcnt == 7) begin
                    m_out = m_acc; m_valid = 1; m_pcnt = 0;
                end else begin
                    m_pcnt++;
                end
                m_run = 1;
            end
            if (src_wr) begin
                m_buf = src_data; m_bfull = 1;
            end
        end
    end

    localparam int NV = 8;
    localparam logic [7:0] VEC_BYTE [NV] = '{8'hFF, 8'h7E, 8'h00, 8'hA5, 8'h1F, 8'hF8, 8'h3E, 8'hC3};
    localparam int         VEC_GAP  [NV] = '{11, 11, 11, 12, 11, 14, 11, 11};

    logic [7:0] rd_log [64];
    int         n_rd = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input bit wr, input logic [7:0] d, input bit ar);
        @(negedge clk);
        chk(out_valid === m_valid, "R3 out_valid vs model", 32'(out_valid), 32'(m_valid));
        chk(crc_value === m_crc, "R5 crc_value vs model", 32'(crc_value), 32'(m_crc));
        if (ar && out_valid) begin
            chk(out_data === m_out, "R2 out_data vs model", 32'(out_data), 32'(m_out));
            if (n_rd < 64) rd_log[n_rd] = out_data;
            n_rd++;
            out_rd = 1'b1;
        end else begin
            out_rd = 1'b0;
        end
        src_wr   = wr;
        src_data = d;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  held_d;
        logic [15:0] held_c;
        int          base;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 out_valid after reset", 32'(out_valid), 0);
        chk(out_data === 8'h00, "R8 out_data after reset", 32'(out_data), 0);
        chk(crc_value === 16'hFFFF, "R8 crc after reset", 32'(crc_value), 32'hFFFF);
        rst = 1'b0;

        // R7: enabled but nothing written
        tx_en = 1'b1;
        for (int i = 0; i < 20; i++) tick(0, 0, 1);
        chk(out_valid === 1'b0, "R7 no output without byte", 32'(out_valid), 0);
        chk(crc_value === 16'hFFFF, "R7 crc idle before start", 32'(crc_value), 32'hFFFF);

        // R1/R2: FF then 00, hand-computed words
        base = n_rd;
        tick(1, 8'hFF, 1);
        tick(0, 0, 1);
        tick(1, 8'h00, 1);
        for (int i = 0; i < 24; i++) tick(0, 0, 1);
        chk(rd_log[base] === 8'hDF, "R1 stuffed word after FF", 32'(rd_log[base]), 32'hDF);
        chk(rd_log[base+1] === 8'h01, "R2 LSB-first packing", 32'(rd_log[base+1]), 32'h01);

        // R4: restart with FF followed by idle fill
        tick(0, 0, 1);
        tx_en = 1'b0;
        tick(0, 0, 1);
        chk(crc_value === 16'hFFFF, "R6 crc reseeded", 32'(crc_value), 32'hFFFF);
        tx_en = 1'b1;
        base = n_rd;
        tick(1, 8'hFF, 1);
        for (int i = 0; i < 30; i++) tick(0, 0, 1);
        chk(rd_log[base] === 8'hDF, "R4 fill word 0", 32'(rd_log[base]), 32'hDF);
        chk(rd_log[base+1] === 8'hF7, "R4 fill word 1", 32'(rd_log[base+1]), 32'hF7);
        chk(rd_log[base+2] === 8'h7D, "R4 fill word 2", 32'(rd_log[base+2]), 32'h7D);

        // Table walk: bytes with gaps, model-checked every cycle (R1 R2 R4 R5)
        for (int v = 0; v < NV; v++) begin
            tick(1, VEC_BYTE[v], 1);
            for (int g = 0; g < VEC_GAP[v]; g++) tick(0, 0, 1);
        end
        for (int i = 0; i < 40; i++) tick(0, 0, 1);

        // R3: stall with an unread word
        while (!out_valid) tick(0, 0, 0);
        held_d = out_data;
        held_c = crc_value;
        for (int i = 0; i < 25; i++) tick(0, 0, 0);
        chk(out_valid === 1'b1, "R3 valid held while unread", 32'(out_valid), 1);
        chk(out_data === held_d, "R3 word held while unread", 32'(out_data), 32'(held_d));
        chk(crc_value === held_c, "R3 crc frozen while stalled", 32'(crc_value), 32'(held_c));

        // R6: disable while a word is waiting
        tx_en = 1'b0;
        tick(0, 0, 0);
        tick(0, 0, 0);
        chk(crc_value === 16'hFFFF, "R6 crc seed on disable", 32'(crc_value), 32'hFFFF);
        chk(out_valid === 1'b1, "R6 valid kept on disable", 32'(out_valid), 1);
        chk(out_data === held_d, "R6 word kept on disable", 32'(out_data), 32'(held_d));
        tick(0, 0, 1);
        tick(0, 0, 1);
        chk(out_valid === 1'b0, "R3 read clears valid", 32'(out_valid), 0);

        // R9: overwrite a waiting byte while disabled, then run
        tick(1, 8'hAA, 1);
        tick(1, 8'h55, 1);
        tick(0, 0, 1);
        tx_en = 1'b1;
        base = n_rd;
        for (int i = 0; i < 14; i++) tick(0, 0, 1);
        chk(rd_log[base] === 8'h55, "R9 replaced byte converted", 32'(rd_log[base]), 32'h55);
        for (int i = 0; i < 30; i++) tick(0, 0, 1);
        chk(n_rd >= base + 3, "R3 conversion resumes after reads", 32'(n_rd - base), 3);

        summary();
        $finish;
    end

endmodule